// File: doc/BRIEF.md
# Port Link Status Probe Sequencer

This block fetches the negotiated duplex and speed of one switch port over a simple register-access handshake. A start pulse carries the port number. The sequencer reads the port's status register. If that register already shows link, it decodes duplex and speed straight away. If it shows no link, the block applies a temporary link override in the port's physical-control register, because status is only meaningful while link is present. It then polls status until link appears or a retry budget runs out, decodes the result and always removes the override before it finishes.

Each access puts an address on the request side: a device number equal to a base of 16 plus the port, and a register number of 0 for status or 1 for physical control. The access also carries a read or write flag and the write data. The request is held until a one-cycle acknowledge returns the read data and a transport error flag. The caller gets a one-cycle done pulse together with a duplex flag, a 2-bit speed code and an error flag.

Top module: `link_probe_seq`

## Requirements
- R1: A start while idle latches the port number. The first access is a read of register 0 at device 16 plus the port. No request is raised while idle.
- R2: If status bit 11 (link) is 1 on the first read, the result is decoded and done follows, with no access to register 1.
- R3: Duplex output equals status bit 10. The speed code equals status bits 9:8 when those are 0 (10 Mb/s), 1 (100 Mb/s) or 2 (1000 Mb/s). The value 3 yields code 0.
- R4: If the first status read shows no link, register 1 is read and then written back with bits 5 and 4 set and every other bit unchanged.
- R5: After the override, status is re-read until bit 11 is 1, with at most MAX_POLL (default 100) reads. Decoding uses the read that showed link.
- R6: If MAX_POLL polls never show link, the error output is set.
- R7: Whenever the override write was issued, the sequence ends with a read of register 1 and a write of that value with bits 5 and 4 cleared and the other bits kept. This holds on the timeout path too.
- R8: An access acknowledged with the transport error flag stops the sequence with the error output set. If the override write had been issued, the removal read and write of R7 are still performed.
- R9: Done is high for exactly one cycle per sequence. Duplex, speed and error hold their values until the next start. A start while busy is ignored.
- R10: A raised request keeps its direction, device, register and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe (taken only when idle) |
| port | input | PORT_W | Port to probe |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| full_duplex | output | 1 | Decoded duplex |
| speed | output | 2 | Speed code: 0 = 10, 1 = 100, 2 = 1000 Mb/s |
| err | output | 1 | Transport error or link timeout |
| acc_req | output | 1 | Access request, held until acknowledged |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_dev | output | DEV_W | Device address |
| acc_reg | output | REG_W | Register address |
| acc_wdata | output | DATA_W | Write data |
| acc_ack | input | 1 | One-cycle access acknowledge |
| acc_err | input | 1 | Transport error, valid with acknowledge |
| acc_rdata | input | DATA_W | Read data, valid with acknowledge |

## Verification
A wrong state transition shows at the access port at the very next request. It appears as an extra, missing or misaddressed access, or a write whose override bits are wrong. The bench compares each access against its expected trace as it is acknowledged. A bad retry counter shows only at the end of the polling window, as a wrong number of status reads or a wrong error flag at done. The timeout and last-chance cases aim at exactly that window. A decode or hold fault shows on the result outputs in the cycle of done and in the idle cycles after it.

// File: rtl/link_probe_seq.sv
module link_probe_seq #(
  parameter int PORT_W   = 4,
  parameter int DEV_W    = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int DEV_BASE = 16,
  parameter int MAX_POLL = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PORT_W-1:0] port,
  output logic              busy,
  output logic              done,
  output logic              full_duplex,
  output logic [1:0]        speed,
  output logic              err,
  output logic              acc_req,
  output logic              acc_wr,
  output logic [DEV_W-1:0]  acc_dev,
  output logic [REG_W-1:0]  acc_reg,
  output logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_ack,
  input  logic              acc_err,
  input  logic [DATA_W-1:0] acc_rdata
);
  localparam int CNT_W = (MAX_POLL > 1) ? $clog2(MAX_POLL) : 1;
  localparam int LINK_B = 11;
  localparam int DUP_B  = 10;
  localparam int SPD_LO = 8;
  localparam logic [DATA_W-1:0] OVR_MASK = DATA_W'(16'h0030);
  localparam logic [REG_W-1:0] REG_STAT = '0;
  localparam logic [REG_W-1:0] REG_PCTL = REG_W'(1);

  typedef enum logic [2:0] {IDLE, RD_ST, RD_PC, WR_PC, POLL, UN_RD, UN_WR, FIN} st_t;

  st_t               state;
  logic [PORT_W-1:0] port_q;
  logic [DATA_W-1:0] pc_q;
  logic [CNT_W-1:0]  cnt;

  wire link_seen = acc_rdata[LINK_B];
  wire [1:0] spd_raw = acc_rdata[SPD_LO+1:SPD_LO];
  wire [1:0] spd_dec = (spd_raw == 2'd3) ? 2'd0 : spd_raw;

  assign busy      = state != IDLE;
  assign done      = state == FIN;
  assign acc_req   = state inside {RD_ST, RD_PC, WR_PC, POLL, UN_RD, UN_WR};
  assign acc_wr    = state inside {WR_PC, UN_WR};
  assign acc_reg   = (state inside {RD_ST, POLL}) ? REG_STAT : REG_PCTL;
  assign acc_dev   = DEV_W'(DEV_BASE) + DEV_W'(port_q);
  assign acc_wdata = (state == WR_PC) ? (pc_q | OVR_MASK) : (pc_q & ~OVR_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= IDLE;
      port_q      <= '0;
      pc_q        <= '0;
      cnt         <= '0;
      err         <= 1'b0;
      full_duplex <= 1'b0;
      speed       <= 2'd0;
    end else begin
      case (state)
        IDLE: if (start) begin
          port_q      <= port;
          err         <= 1'b0;
          full_duplex <= 1'b0;
          speed       <= 2'd0;
          cnt         <= '0;
          state       <= RD_ST;
        end
        RD_ST: if (acc_ack) begin
          if (acc_err) begin
            err   <= 1'b1;
            state <= FIN;
          end else if (link_seen) begin
            full_duplex <= acc_rdata[DUP_B];
            speed       <= spd_dec;
            state       <= FIN;
          end else begin
            state <= RD_PC;
          end
        end
        RD_PC: if (acc_ack) begin
          if (acc_err) begin
            err   <= 1'b1;
            state <= FIN;
          end else begin
            pc_q  <= acc_rdata;
            state <= WR_PC;
          end
        end
        WR_PC: if (acc_ack) begin
          cnt <= '0;
          if (acc_err) begin
            err   <= 1'b1;
            state <= UN_RD;
          end else begin
            state <= POLL;
          end
        end
        POLL: if (acc_ack) begin
          if (acc_err) begin
            err   <= 1'b1;
            state <= UN_RD;
          end else if (link_seen) begin
            full_duplex <= acc_rdata[DUP_B];
            speed       <= spd_dec;
            state       <= UN_RD;
          end else if (cnt == CNT_W'(MAX_POLL - 1)) begin
            err   <= 1'b1;
            state <= UN_RD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        UN_RD: if (acc_ack) begin
          if (acc_err) begin
            err   <= 1'b1;
            state <= FIN;
          end else begin
            pc_q  <= acc_rdata;
            state <= UN_WR;
          end
        end
        UN_WR: if (acc_ack) begin
          if (acc_err) err <= 1'b1;
          state <= FIN;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_probe_seq_chk.sv
module link_probe_seq_chk #(
  parameter int DEV_W    = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int MAX_POLL = 100
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              acc_req,
  input logic              acc_wr,
  input logic [DEV_W-1:0]  acc_dev,
  input logic [REG_W-1:0]  acc_reg,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              acc_ack
);
  logic [15:0] st_reads;

  always_ff @(posedge clk) begin
    if (rst || (start && !busy)) st_reads <= '0;
    else if (acc_req && acc_ack && !acc_wr && acc_reg == '0) st_reads <= st_reads + 1'b1;
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    acc_req && !acc_ack |=> acc_req && $stable(acc_wr) && $stable(acc_dev)
                            && $stable(acc_reg) && $stable(acc_wdata));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst) !busy |-> !acc_req);

  p_write_target_r7: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_wr |-> acc_reg == REG_W'(1)
                          && (acc_wdata[5:4] == 2'b11 || acc_wdata[5:4] == 2'b00));

  p_poll_bound_r5: assert property (@(posedge clk) disable iff (rst)
    st_reads <= 16'(MAX_POLL + 1));
endmodule

bind link_probe_seq link_probe_seq_chk #(
  .DEV_W(DEV_W), .REG_W(REG_W), .DATA_W(DATA_W), .MAX_POLL(MAX_POLL)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .acc_req(acc_req), .acc_wr(acc_wr), .acc_dev(acc_dev), .acc_reg(acc_reg),
  .acc_wdata(acc_wdata), .acc_ack(acc_ack)
);

// File: tb/link_probe_seq_tb.sv
module link_probe_seq_tb;
  localparam int MAXP = 100;
  localparam int LAT  = 2;

  logic clk = 0, rst = 1, start = 0;
  logic [3:0] port_in = 0;
  logic busy, done, full_duplex, err, acc_req, acc_wr;
  logic [1:0] speed;
  logic [4:0] acc_dev, acc_reg;
  logic [15:0] acc_wdata, acc_rdata = 0;
  logic acc_ack = 0, acc_err = 0;

  always #5 clk = ~clk;

  link_probe_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .port(port_in), .busy(busy), .done(done),
    .full_duplex(full_duplex), .speed(speed), .err(err), .acc_req(acc_req),
    .acc_wr(acc_wr), .acc_dev(acc_dev), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
    .acc_ack(acc_ack), .acc_err(acc_err), .acc_rdata(acc_rdata)
  );

  typedef struct { bit wr; int dev; int rg; int wdata; int ph; } acc_t;
  acc_t exp_q[$];
  acc_t full[$];

  int tests = 0, fails = 0, cyc = 0, wcnt = 0, acc_idx = 0, polls = 0;
  bit m_link; int m_appear; bit m_dup; bit [1:0] m_spd; int m_err_at;
  logic [15:0] pc_mem;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic serve();
    acc_t e;
    bit ef;
    bit lk;
    logic [15:0] rd;
    ef = (acc_idx == m_err_at);
    if (exp_q.size() == 0) begin
      chk(0, "R2", "unexpected access reg", int'(acc_reg), -1);
    end else begin
      e = exp_q.pop_front();
      chk(acc_wr == e.wr, "R1", "access direction", int'(acc_wr), e.wr);
      chk(int'(acc_dev) == e.dev, "R1", "access device", int'(acc_dev), e.dev);
      chk(int'(acc_reg) == e.rg, "R4", "access register", int'(acc_reg), e.rg);
      if (e.wr) chk(int'(acc_wdata) == e.wdata, "R7", "write data", int'(acc_wdata), e.wdata);
    end
    rd = 16'h0;
    if (!acc_wr) begin
      if (acc_reg == 0) begin
        if (pc_mem[5:4] == 2'b11) begin
          lk = (polls >= m_appear);
          polls++;
        end else lk = m_link;
        rd = {4'h0, lk, m_dup, m_spd, 8'h5A};
      end else rd = pc_mem;
    end else if (!ef) pc_mem = acc_wdata;
    acc_idx++;
    acc_rdata <= rd;
    acc_err   <= ef;
    acc_ack   <= 1'b1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (acc_ack) begin
      acc_ack <= 0; acc_err <= 0;
    end else if (!rst && acc_req) begin
      if (wcnt == LAT) begin wcnt = 0; serve(); end
      else wcnt++;
    end
    if (done) chk(exp_q.size() == 0, "R9", "accesses left at done", exp_q.size(), 0);
  end

  task automatic add(bit wr, int dev, int rg, int wd, int ph);
    acc_t a;
    a.wr = wr; a.dev = dev; a.rg = rg; a.wdata = wd; a.ph = ph;
    full.push_back(a);
  endtask

  task automatic run(int p, bit li, int ap, bit d, bit [1:0] s, int ea,
                     logic [15:0] ipc, bit mid, string req);
    int dev = 16 + p;
    int n;
    bit xerr;
    acc_t u;
    m_link = li; m_appear = ap; m_dup = d; m_spd = s; m_err_at = ea;
    pc_mem = ipc; acc_idx = 0; polls = 0;
    full.delete(); exp_q.delete();
    add(0, dev, 0, 0, 0);
    if (!li) begin
      add(0, dev, 1, 0, 1);
      add(1, dev, 1, int'(ipc | 16'h0030), 2);
      n = (ap < MAXP) ? ap + 1 : MAXP;
      for (int i = 0; i < n; i++) add(0, dev, 0, 0, 3);
      add(0, dev, 1, 0, 4);
      add(1, dev, 1, int'(ipc & ~16'h0030), 5);
    end
    for (int i = 0; i < full.size(); i++) begin
      exp_q.push_back(full[i]);
      if (i == ea) begin
        if (full[i].ph == 2 || full[i].ph == 3) begin
          u = full[full.size() - 2]; exp_q.push_back(u);
          u = full[full.size() - 1]; exp_q.push_back(u);
        end
        break;
      end
    end
    xerr = (ea >= 0 && ea < full.size()) || (!li && ap >= MAXP);
    @(negedge clk); start = 1; port_in = 4'(p);
    @(negedge clk); start = 0;
    if (mid) begin
      repeat (2) @(negedge clk);
      start = 1; port_in = 4'(p ^ 1);
      @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    chk(err == xerr, req, "error flag", err, xerr);
    if (!xerr) begin
      chk(full_duplex == d, "R3", "duplex", full_duplex, d);
      chk(speed == ((s == 2'd3) ? 2'd0 : s), "R3", "speed code", speed, (s == 2'd3) ? 0 : s);
    end
    if (!li && (ea < 0 || ea >= full.size()))
      chk(pc_mem == ipc, "R7", "override removed", int'(pc_mem), int'(ipc));
    @(negedge clk);
    chk(done == 0, "R9", "done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(!busy && err == xerr, "R9", "result held", err, xerr);
    chk(exp_q.size() == 0, req, "missing accesses", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0 && acc_req == 0 && err == 0 && speed == 0 && busy == 0,
        "R1", "reset state", {done, acc_req, err, busy}, 0);
    rst = 0;
    run(3, 1, 0, 1, 2'd2, -1, 16'h0000, 0, "R2");
    run(7, 1, 0, 0, 2'd3, -1, 16'h0000, 0, "R3");
    run(0, 1, 0, 1, 2'd1, -1, 16'h0000, 0, "R3");
    run(5, 0, 0, 1, 2'd1, -1, 16'hC00B, 0, "R4");
    run(9, 0, 7, 0, 2'd2, -1, 16'h8A4F, 0, "R5");
    run(2, 0, 1000, 1, 2'd2, -1, 16'h0101, 0, "R6");
    run(4, 0, 99, 1, 2'd0, -1, 16'h00C0, 0, "R5");
    run(1, 0, 0, 1, 2'd2, 0, 16'h0000, 0, "R8");
    run(6, 0, 3, 1, 2'd2, 2, 16'h1200, 0, "R8");
    run(8, 0, 5, 1, 2'd2, 4, 16'h3300, 0, "R8");
    run(10, 0, 0, 1, 2'd1, 4, 16'h0007, 0, "R8");
    run(15, 0, 2, 0, 2'd1, -1, 16'hF00F, 1, "R9");
    run(12, 1, 0, 0, 2'd0, -1, 16'h0000, 1, "R10");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule